// File: doc/BRIEF.md
# Status Blink Encoder

This block drives one active-low, open-drain status pin from seven condition flags that can be active at the same time. Each condition has its own blink frequency. The pin is pulled low for one half-period and then released for one half-period, and this repeats. When more than one condition is active, the fastest blink is shown. While the supply input is not valid, the pin floats, so an external pull-up holds it high. When the input is valid but charging is disabled, or no condition is active, the pin is held low.

Every half-period comes from one counter. It is reloaded with a cycle count that is computed at elaboration time from the clock frequency parameter. When the shown condition changes, the blink phase starts again from the beginning of a low half. This means a shortened pulse never reaches the pin. The end-of-charge indication is held from the moment it is seen until the input stops being valid.

Top module: `stat_blink_enc`

## Requirements
- R1: When `in_valid` was low at the previous clock edge, `stat_oe` is 0, so the pin is released.
- R2: When `in_valid` was high and `chg_en` was low at the previous edge, `stat_oe` is 1 (pin driven low), whatever `cond_i` holds.
- R3: When the input is valid, charging is enabled, and no condition is active (no `cond_i` bit set and no end-of-charge held), `stat_oe` is 1.
- R4: Condition encoding on `cond_i` is as follows. Bit 6 is temperature fault at 16.2 Hz. Bit 5 is thermal warning at 14.2 Hz. Bit 4 is below-pre-charge fault at 12.8 Hz. Bit 3 is timeout at 10.2 Hz. Bit 2 is overcharge at 8.2 Hz. Bit 1 is charging at 6.2 Hz. Bit 0 is end of charge at 4.1 Hz. One half-period is floor(CLK_HZ*5/r) clock cycles, where r is the rate in tenths of a hertz. A blink is one half-period with `stat_oe`=1 followed by one half-period with `stat_oe`=0.
- R5: Among the active conditions, the one with the highest blink rate is shown.
- R6: When the shown condition clears and lower-rate conditions remain active, the highest of the remaining ones is shown next.
- R7: An end-of-charge flag seen while the input is valid stays active until `in_valid` goes low, even if `cond_i[0]` falls.
- R8: Whenever the shown state changes, the output follows one cycle later. A new blink always starts with a full low half-period, even if the change happens in the middle of a phase.
- R9: During and right after reset, `stat_oe` is 0.
- R10: `stat_lvl` equals the pin level with the pull-up applied. It is 0 while `stat_oe` is 1 and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Supply input is within its valid window |
| chg_en | input | 1 | Charging enabled |
| cond_i | input | 7 | Condition flags, encoded as in R4 |
| stat_oe | output | 1 | Open-drain enable: 1 pulls the pin low |
| stat_lvl | output | 1 | Resolved pin level with the pull-up applied |

## Verification
The bench builds the block with CLK_HZ = 1640. With this value the half-periods run from 50 cycles (temperature fault) to 200 cycles (end of charge). At the default sleep-clock frequency they would be thousands of cycles long. These short periods allow the bench to:
- measure full low and high halves for every rate;
- switch the shown condition in the middle of a phase;
- run long random sequences of priority changes within a few tens of thousands of cycles.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int NUM_COND = 7;
    localparam int IDX_W    = $clog2(NUM_COND);

    typedef enum logic [1:0] {
        PIN_FLOAT = 2'd0,
        PIN_HOLD  = 2'd1,
        PIN_BLINK = 2'd2
    } pin_mode_e;

    typedef struct packed {
        pin_mode_e          mode;
        logic [IDX_W-1:0]   idx;
    } pin_sel_t;

    // Blink rate of each condition slot, in tenths of a hertz.
    function automatic int unsigned rate_dhz(input int unsigned slot);
        case (slot)
            0:       return 41;
            1:       return 62;
            2:       return 82;
            3:       return 102;
            4:       return 128;
            5:       return 142;
            default: return 162;
        endcase
    endfunction

    // Clock cycles in one half-period: clk_hz / (2 * rate/10).
    function automatic int unsigned half_cyc(input int unsigned clk_hz,
                                             input int unsigned slot);
        longint unsigned h;
        h = (longint'(clk_hz) * 5) / longint'(rate_dhz(slot));
        if (h == 0) h = 1;
        return int'(h);
    endfunction

endpackage

// File: rtl/stat_rate_pick.sv
module stat_rate_pick
    import stat_pkg::*;
(
    input  logic [NUM_COND-1:0] act_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o
);
    int unsigned best_rate;

    // Rank by blink rate, not by slot position.
    always_comb begin
        best_rate = 0;
        any_o     = 1'b0;
        idx_o     = '0;
        for (int i = 0; i < NUM_COND; i++) begin
            if (act_i[i] && (rate_dhz(i) > best_rate)) begin
                best_rate = rate_dhz(i);
                idx_o     = IDX_W'(i);
                any_o     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/stat_blink_timer.sv
module stat_blink_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] len_m1,
    output logic             phase_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_o <= 1'b0;
        end else if (restart) begin
            cnt_q   <= len_m1;
            phase_o <= 1'b0;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q   <= len_m1;
                phase_o <= ~phase_o;
            end else begin
                cnt_q   <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/stat_blink_enc.sv
module stat_blink_enc
    import stat_pkg::*;
#(
    parameter int unsigned CLK_HZ = 32768
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                chg_en,
    input  logic [NUM_COND-1:0] cond_i,
    output logic                stat_oe,
    output logic                stat_lvl
);
    // Slot 0 has the lowest rate, hence the longest half-period.
    localparam int unsigned HALF_MAX = half_cyc(CLK_HZ, 0);
    localparam int          CNT_W    = $clog2(HALF_MAX + 1);

    logic                eoc_q;
    logic [NUM_COND-1:0] act;
    logic                any_act;
    logic [IDX_W-1:0]    top_idx;
    pin_sel_t            sel_n, sel_q;
    logic                restart;
    logic                phase;
    logic [CNT_W-1:0]    len_m1;

    assign act = cond_i | {{(NUM_COND-1){1'b0}}, eoc_q};

    stat_rate_pick u_pick (
        .act_i (act),
        .any_o (any_act),
        .idx_o (top_idx)
    );

    always_comb begin
        sel_n.idx = '0;
        if (!in_valid) begin
            sel_n.mode = PIN_FLOAT;
        end else if (!chg_en || !any_act) begin
            sel_n.mode = PIN_HOLD;
        end else begin
            sel_n.mode = PIN_BLINK;
            sel_n.idx  = top_idx;
        end
    end

    assign restart = (sel_n != sel_q);
    assign len_m1  = CNT_W'(half_cyc(CLK_HZ, int'(sel_n.idx)) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_q <= 1'b0;
            sel_q <= '{mode: PIN_FLOAT, idx: '0};
        end else begin
            if (!in_valid)     eoc_q <= 1'b0;
            else if (cond_i[0]) eoc_q <= 1'b1;
            sel_q <= sel_n;
        end
    end

    stat_blink_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (sel_q.mode == PIN_BLINK),
        .len_m1  (len_m1),
        .phase_o (phase)
    );

    always_comb begin
        case (sel_q.mode)
            PIN_HOLD:  stat_oe = 1'b1;
            PIN_BLINK: stat_oe = ~phase;
            default:   stat_oe = 1'b0;
        endcase
    end

    assign stat_lvl = ~stat_oe;
endmodule

// File: rtl/stat_blink_chk.sv
module stat_blink_chk
    import stat_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                chg_en,
    input logic [NUM_COND-1:0] cond_i,
    input logic                stat_oe,
    input logic                eoc_q,
    input logic [NUM_COND-1:0] act,
    input pin_sel_t            sel_q,
    input pin_sel_t            sel_n,
    input logic                restart
);
    AST_FLOAT_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> !stat_oe); // R1

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && !chg_en)) |-> stat_oe); // R2

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && chg_en && (act == '0))) |-> stat_oe); // R3

    AST_FASTEST_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sel_q.mode == PIN_BLINK)) |-> (($past(act) >> sel_q.idx) == 7'd1)); // R5

    AST_EOC_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && (cond_i[0] || eoc_q))) |-> eoc_q); // R7

    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
        (restart && (sel_n.mode != PIN_FLOAT)) |=> stat_oe); // R8
endmodule

bind stat_blink_enc stat_blink_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .chg_en   (chg_en),
    .cond_i   (cond_i),
    .stat_oe  (stat_oe),
    .eoc_q    (eoc_q),
    .act      (act),
    .sel_q    (sel_q),
    .sel_n    (sel_n),
    .restart  (restart)
);

// File: tb/sim_stat_blink_enc.sv
`timescale 1ns/1ps
module sim_stat_blink_enc;
    localparam int unsigned CLK_HZ = 1640;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       chg_en = 1'b0;
    logic [6:0] cond_i = '0;
    logic       stat_oe, stat_lvl;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit chk_on = 1'b0;

    always #2 clk = ~clk;

    stat_blink_enc #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .chg_en(chg_en),
        .cond_i(cond_i), .stat_oe(stat_oe), .stat_lvl(stat_lvl)
    );

    function automatic int rate_of(input int s);
        case (s)
            0: return 41;   1: return 62;   2: return 82;   3: return 102;
            4: return 128;  5: return 142;  default: return 162;
        endcase
    endfunction

    function automatic int half_of(input int s);
        return int'(CLK_HZ) * 5 / rate_of(s);
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            if (n_fail < 30)
                $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act_v, exp_v, cyc);
        end
    endtask

    // Reference model built from the requirements
    bit m_eoc;
    int m_mode, m_idx, m_cnt;
    bit m_ph;

    always @(posedge clk) begin
        int nm, ni;
        logic [6:0] a;
        cyc++;
        if (rst) begin
            m_eoc = 0; m_mode = 0; m_idx = 0; m_cnt = 0; m_ph = 0;
        end else begin
            a  = cond_i | {6'b0, m_eoc};
            ni = 0;
            if (!in_valid)     nm = 0;
            else if (!chg_en)  nm = 1;
            else if (a != 0) begin
                nm = 2;
                for (int s = 0; s < 7; s++) if (a[s]) ni = s;
            end else           nm = 1;
            if (!in_valid)      m_eoc = 0;
            else if (cond_i[0]) m_eoc = 1;
            if (nm != m_mode || ni != m_idx) begin
                m_mode = nm; m_idx = ni; m_cnt = half_of(ni) - 1; m_ph = 0;
            end else if (m_mode == 2) begin
                if (m_cnt == 0) begin m_cnt = half_of(m_idx) - 1; m_ph = ~m_ph; end
                else m_cnt--;
            end
        end
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            report();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            bit exp_oe;
            string tag;
            exp_oe = (m_mode == 1) || (m_mode == 2 && !m_ph);
            if (m_mode == 0)      tag = "R1";
            else if (m_mode == 2) tag = "R5";
            else if (!chg_en)     tag = "R2";
            else                  tag = "R3";
            chk(stat_oe === exp_oe, tag, int'(stat_oe), int'(exp_oe));
            chk(stat_lvl === ~stat_oe, "R10", int'(stat_lvl), int'(~stat_oe));
        end
    end

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (stat_oe === lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lo, hi;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        chk(stat_oe === 1'b0, "R9", int'(stat_oe), 0);
        chk(stat_lvl === 1'b1, "R9", int'(stat_lvl), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(stat_oe === 1'b0, "R9", int'(stat_oe), 0);
        chk_on = 1'b1;

        // disabled with a fault pending: held low
        in_valid = 1; chg_en = 0; cond_i = 7'b1000000;
        @(negedge clk);
        chk(stat_oe === 1'b1, "R2", int'(stat_oe), 1);
        cond_i = 0; chg_en = 1;
        @(negedge clk);
        chk(stat_oe === 1'b1, "R3", int'(stat_oe), 1);

        // each rate alone, slots 6 down to 1
        for (int s = 6; s >= 1; s--) begin
            cond_i = 7'(1 << s);
            @(negedge clk);
            run_len(1'b1, lo);
            run_len(1'b0, hi);
            chk(lo == half_of(s), "R4", lo, half_of(s));
            chk(hi == half_of(s), "R4", hi, half_of(s));
            cond_i = 0;
            @(negedge clk);
        end

        // priority then fallback
        cond_i = 7'b0010010;
        @(negedge clk);
        run_len(1'b1, lo);
        chk(lo == half_of(4), "R5", lo, half_of(4));
        cond_i = 7'b0000010;
        @(negedge clk);
        run_len(1'b1, lo);
        chk(lo == half_of(1), "R6", lo, half_of(1));

        // mid-phase switch restarts with a full low half
        cond_i = 7'b1000000;
        repeat (30) @(negedge clk);
        cond_i = 7'b0100000;
        @(negedge clk);
        run_len(1'b1, lo);
        chk(lo == half_of(5), "R8", lo, half_of(5));

        // end-of-charge pulse is held while input stays valid
        cond_i = 0;
        repeat (3) @(negedge clk);
        cond_i = 7'b0000001;
        @(negedge clk);
        cond_i = 0;
        run_len(1'b1, lo);
        run_len(1'b0, hi);
        chk(lo == half_of(0), "R7", lo, half_of(0));
        chk(hi == half_of(0), "R7", hi, half_of(0));
        in_valid = 0;
        @(negedge clk);
        chk(stat_oe === 1'b0, "R1", int'(stat_oe), 0);
        in_valid = 1;
        repeat (250) @(negedge clk);
        chk(stat_oe === 1'b1, "R7", int'(stat_oe), 1);

        // constrained random segments
        for (int k = 0; k < 150; k++) begin
            in_valid = ($urandom % 8) != 0;
            chg_en   = ($urandom % 6) != 0;
            cond_i   = 7'($urandom & $urandom & $urandom);
            repeat (20 + ($urandom % 400)) @(negedge clk);
        end

        chk_on = 1'b0;
        report();
        $finish;
    end
endmodule